// File: doc/BRIEF.md
# Burst-of-Two Separate-Port DDR SRAM Core

This block is a synthesizable model of a synchronous static memory that has one port for reads and a separate port for writes. Both ports move data in fixed bursts of two beats on a double-data-rate bus. One system clock runs at twice the K rate, so every clock edge of the model is one beat slot. After reset the slots alternate between a K-rising slot and a K-falling slot, and the first edge after reset is a K-rising slot.

The storage word is twice as wide as the data bus, so one address selects a pair of beats. A write takes its command and its first beat in a K-falling slot and its second beat in the next K-rising slot. The two beats are then committed to the storage in a single access, with byte masks that were captured alongside each beat. A read command in a K-rising slot fetches one double-width word. That word leaves the block as two beats, low half first, two K cycles later, with a valid flag. A read and a write may be issued in the same K cycle. Reads always see every write that was commanded before them, including one whose second beat arrives in the same slot as the read command.

Top module: `qburst_sram`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is all zeros, no operation is pending, and every storage word reads back as zero.
- R2: A read is accepted only when `rd_req_n` is low in a K-rising slot (even slot counting from the first edge after reset, slot 0). A low `rd_req_n` in a K-falling slot produces no read data.
- R3: A read accepted at slot edge t drives the low beat (bits DATA_W-1:0 of the stored word) on `rd_data` after edge t+4, and the high beat after edge t+5.
- R4: `rd_valid` is 1 after exactly those edges that place a read beat on `rd_data`, and 0 after every other edge.
- R5: A write is accepted when `wr_req_n` is low in a K-falling slot. Its data and lane enables in that slot form the low beat. The data and lane enables in the following K-rising slot form the high beat. Both beats are committed in a single access.
- R6: Lane enables are active-low, one per 9-bit lane of a beat, with bit i covering data bits 9i+8:9i. A lane whose enable is high keeps its previous stored content.
- R7: A read and a write issued in the same K cycle (read in the K-rising slot, write in the following K-falling slot) to the same address return the data that was stored before that write.
- R8: A read commanded in the K-rising slot that carries the second beat of a write to the same address returns the newly merged word, with that write's lane masks applied.
- R9: While `rd_valid` is 0, `rd_data` keeps its last value.
- R10: Reads issued in consecutive K cycles produce an unbroken stream of beats, and `rd_valid` stays high across them.
- R11: A low `wr_req_n` in a K-rising slot is ignored and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat-slot clock, twice the K rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_n | input | 1 | Active-low read command, sampled in K-rising slots |
| rd_addr | input | ADDR_W | Read word address |
| wr_req_n | input | 1 | Active-low write command, sampled in K-falling slots |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write beat data |
| wr_lane_n | input | DATA_W/9 | Active-low lane enables for the current write beat |
| rd_data | output | DATA_W | Read beat data |
| rd_valid | output | 1 | High in slots carrying read data |

## Verification
The hardest case to reach is a read whose command lands in the same slot as the second beat of a write to the same address. In that slot the storage still holds the old word, and the correct answer exists only as a merge on the forwarding path. The bench drives this collision on purpose, with partial lane masks, so that both the old and the new lanes must appear in the output. It also places a read one slot earlier, in the same K cycle as the write, where the old word is the correct answer. A long run of random commands over only four addresses then produces these collisions and back-to-back read streams many more times. A behavioural shadow memory that applies writes in command order predicts every beat slot.

// File: rtl/qburst_pkg.sv
package qburst_pkg;

  // Beat slot kinds; the first edge after reset is a K-rising slot.
  typedef enum logic {
    SLOT_KRISE = 1'b0,
    SLOT_KFALL = 1'b1
  } slot_e;

  localparam int LANE_BITS = 9;

  function automatic slot_e slot_after(slot_e cur);
    return (cur == SLOT_KRISE) ? SLOT_KFALL : SLOT_KRISE;
  endfunction

endpackage

// File: rtl/qburst_wr_demux.sv
module qburst_wr_demux
  import qburst_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  localparam int WIDE_W  = 2 * DATA_W,
  localparam int WLANES  = 2 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_e             slot,
  input  logic              wr_req_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_lane_n,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [WIDE_W-1:0] commit_data,
  output logic [WLANES-1:0] commit_keep
);

  // Event: write command accepted in this slot (R5).
  logic wr_take;
  assign wr_take = !wr_req_n && (slot == SLOT_KFALL);

  logic              lo_pend;
  logic [ADDR_W-1:0] lo_addr;
  logic [DATA_W-1:0] lo_data;
  logic [LANES-1:0]  lo_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_pend <= 1'b0;
      lo_addr <= '0;
      lo_data <= '0;
      lo_keep <= '0;
    end else begin
      lo_pend <= wr_take;
      if (wr_take) begin
        lo_addr <= wr_addr;
        lo_data <= wr_data;
        lo_keep <= ~wr_lane_n;
      end
    end
  end

  // The second beat is taken straight from the pins in the commit slot.
  assign commit_en   = lo_pend;
  assign commit_addr = lo_addr;
  assign commit_data = {wr_data, lo_data};
  assign commit_keep = {~wr_lane_n, lo_keep};

  // R5: commits only land in K-rising slots.
  a_r5_commit_krise: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> (slot == SLOT_KRISE));

  // R5: each commit follows a write command one slot earlier.
  a_r5_commit_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> $past(wr_take));

  // R11: a command in a K-rising slot never starts a commit.
  a_r11_no_krise_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req_n && slot == SLOT_KRISE) |=> !commit_en);

endmodule

// File: rtl/qburst_array.sv
module qburst_array #(
  parameter int WIDE_W = 36,
  parameter int ADDR_W = 6,
  parameter int WLANES = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_en,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [WIDE_W-1:0] commit_data,
  input  logic [WLANES-1:0] commit_keep,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [WIDE_W-1:0] look_word
);

  logic [WIDE_W-1:0] mem [DEPTH];

  // Lane-wise merge: lanes with keep set take the new value.
  function automatic logic [WIDE_W-1:0] lane_merge(
    input logic [WIDE_W-1:0] old_w,
    input logic [WIDE_W-1:0] new_w,
    input logic [WLANES-1:0] keep
  );
    logic [WIDE_W-1:0] res;
    res = old_w;
    for (int i = 0; i < WLANES; i++) begin
      if (keep[i]) res[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    end
    return res;
  endfunction

  logic [WIDE_W-1:0] commit_word;
  logic              fwd_hit;

  assign commit_word = lane_merge(mem[commit_addr], commit_data, commit_keep);
  assign fwd_hit     = commit_en && (look_addr == commit_addr);
  assign look_word   = fwd_hit ? lane_merge(mem[look_addr], commit_data, commit_keep)
                               : mem[look_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit_en) begin
      mem[commit_addr] <= commit_word;
    end
  end

  // R8: a forwarded read word equals what the storage holds one slot later.
  a_r8_fwd_coherent: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |=> (mem[$past(commit_addr)] == $past(look_word)));

  // R6: a commit with no lane enabled leaves the word unchanged.
  a_r6_masked_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && commit_keep == '0) |=> (mem[$past(commit_addr)] == $past(mem[commit_addr])));

endmodule

// File: rtl/qburst_rd_mux.sv
module qburst_rd_mux
  import qburst_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int K_LAT   = 2,
  localparam int WIDE_W = 2 * DATA_W,
  localparam int STAGES = 2 * K_LAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_e             slot,
  input  logic              rd_req_n,
  input  logic [WIDE_W-1:0] look_word,
  output logic              rd_take,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  assign rd_take = !rd_req_n && (slot == SLOT_KRISE);

  logic [STAGES-1:0] stg_v;
  logic [WIDE_W-1:0] stg_w [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v[0] <= 1'b0;
      stg_w[0] <= '0;
    end else begin
      stg_v[0] <= rd_take;
      if (rd_take) stg_w[0] <= look_word;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_v[g] <= 1'b0;
        stg_w[g] <= '0;
      end else begin
        stg_v[g] <= stg_v[g-1];
        stg_w[g] <= stg_w[g-1];
      end
    end
  end

  // Event: low beat leaves in this slot.
  logic              launch;
  logic              hi_pend;
  logic [DATA_W-1:0] hi_beat;

  assign launch = stg_v[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      hi_pend  <= 1'b0;
      hi_beat  <= '0;
    end else if (launch) begin
      rd_data  <= stg_w[STAGES-1][DATA_W-1:0];
      hi_beat  <= stg_w[STAGES-1][WIDE_W-1:DATA_W];
      hi_pend  <= 1'b1;
      rd_valid <= 1'b1;
    end else if (hi_pend) begin
      rd_data  <= hi_beat;
      hi_pend  <= 1'b0;
      rd_valid <= 1'b1;
    end else begin
      rd_valid <= 1'b0;
    end
  end

  // R3: the low beat leaves exactly STAGES slots after the command.
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> $past(rd_take, STAGES));

  // R4: a launched beat is followed by its partner beat.
  a_r4_pair: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> ##1 rd_valid);

  // R2: beats start only in K-rising slots.
  a_r2_krise_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (slot == SLOT_KRISE));

  // R9: output holds while no beat is carried.
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

endmodule

// File: rtl/qburst_sram.sv
module qburst_sram
  import qburst_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6,
  parameter int K_LAT  = 2,
  localparam int LANES  = DATA_W / LANE_BITS,
  localparam int WIDE_W = 2 * DATA_W,
  localparam int WLANES = 2 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_req_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_lane_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  slot_e slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= SLOT_KRISE;
    else        slot <= slot_after(slot);
  end

  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [WIDE_W-1:0] commit_data;
  logic [WLANES-1:0] commit_keep;
  logic [WIDE_W-1:0] look_word;
  logic              rd_take;

  qburst_wr_demux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .slot(slot),
    .wr_req_n(wr_req_n), .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane_n(wr_lane_n),
    .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_keep(commit_keep)
  );

  qburst_array #(.WIDE_W(WIDE_W), .ADDR_W(ADDR_W), .WLANES(WLANES), .LANE_W(LANE_BITS)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_keep(commit_keep),
    .look_addr(rd_addr), .look_word(look_word)
  );

  qburst_rd_mux #(.DATA_W(DATA_W), .K_LAT(K_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n), .slot(slot), .rd_req_n(rd_req_n),
    .look_word(look_word), .rd_take(rd_take),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R7: a read and a commit never happen in a K-falling slot.
  a_r7_slot_split: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take || commit_en) |-> (slot == SLOT_KRISE));

endmodule

// File: tb/qburst_sram_bench.sv
module qburst_sram_bench;
  localparam int DW = 18;
  localparam int AW = 6;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int CLK_NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req_n = 1'b1, wr_req_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [LN-1:0] wr_lane_n = '1;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  always #(CLK_NS/2) clk = ~clk;

  qburst_sram u_qburst_sram (
    .clk(clk), .rst_n(rst_n),
    .rd_req_n(rd_req_n), .rd_addr(rd_addr),
    .wr_req_n(wr_req_n), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_lane_n(wr_lane_n),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int runs = 0, fails = 0, slot_no = 0;
  string tag = "R1";

  // Reference state
  logic [2*DW-1:0] shadow [1 << AW];
  logic            p_v = 1'b0;
  logic [AW-1:0]   p_a;
  logic [DW-1:0]   p_d;
  logic [LN-1:0]   p_bw;
  logic            ring_v [8];
  logic [DW-1:0]   ring_q [8];
  logic [DW-1:0]   last_q = '0;
  logic [DW-1:0]   exp_q;
  logic            exp_v;

  task automatic do_slot(input logic rdn, input logic [AW-1:0] ra,
                         input logic wrn, input logic [AW-1:0] wa,
                         input logic [DW-1:0] dd, input logic [LN-1:0] bw);
    logic [2*DW-1:0] w;
    rd_req_n = rdn; rd_addr = ra; wr_req_n = wrn; wr_addr = wa;
    wr_data = dd; wr_lane_n = bw;
    if (slot_no % 2 == 0) begin
      if (p_v) begin
        for (int i = 0; i < LN; i++) begin
          if (!p_bw[i]) shadow[p_a][i*LW +: LW] = p_d[i*LW +: LW];
          if (!bw[i])   shadow[p_a][DW + i*LW +: LW] = dd[i*LW +: LW];
        end
        p_v = 1'b0;
      end
      if (!rdn) begin
        w = shadow[ra];
        ring_v[(slot_no + 4) % 8] = 1'b1;
        ring_q[(slot_no + 4) % 8] = w[DW-1:0];
        ring_v[(slot_no + 5) % 8] = 1'b1;
        ring_q[(slot_no + 5) % 8] = w[2*DW-1:DW];
      end
    end else if (!wrn) begin
      p_v = 1'b1; p_a = wa; p_d = dd; p_bw = bw;
    end
    if (ring_v[slot_no % 8]) begin
      exp_v = 1'b1; exp_q = ring_q[slot_no % 8]; last_q = exp_q;
      ring_v[slot_no % 8] = 1'b0;
    end else begin
      exp_v = 1'b0; exp_q = last_q;
    end
    slot_no++;
    @(negedge clk);
    runs++;
    if (rd_valid !== exp_v || rd_data !== exp_q) begin
      fails++;
      $display("FAIL %s slot %0d: rd_data=%h rd_valid=%b expected rd_data=%h rd_valid=%b",
               tag, slot_no - 1, rd_data, rd_valid, exp_q, exp_v);
    end
  endtask

  // One K cycle: rising slot (read, high write beat) then falling slot (write, low beat).
  task automatic kc(input logic rdn, input logic [AW-1:0] ra,
                    input logic [DW-1:0] dhi, input logic [LN-1:0] bwhi,
                    input logic wrn, input logic [AW-1:0] wa,
                    input logic [DW-1:0] dlo, input logic [LN-1:0] bwlo);
    do_slot(rdn, ra, 1'b1, '0, dhi, bwhi);
    do_slot(1'b1, '0, wrn, wa, dlo, bwlo);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) kc(1'b1, '0, '0, '1, 1'b1, '0, '0, '1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) shadow[i] = '0;
    for (int i = 0; i < 8; i++) begin ring_v[i] = 1'b0; ring_q[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    runs++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      fails++;
      $display("FAIL R1: rd_data=%h rd_valid=%b expected rd_data=0 rd_valid=0", rd_data, rd_valid);
    end
    rst_n = 1'b1;
    // R1: unwritten word reads as zero
    tag = "R1"; kc(1'b0, 6'd5, '0, '1, 1'b1, '0, '0, '1); idle(3);
    // R5: full write then read (R3 latency checked each slot)
    tag = "R5"; kc(1'b1, '0, '0, '1, 1'b0, 6'd3, 18'h1A5A5, 2'b00);
    kc(1'b1, '0, 18'h2C3C3, 2'b00, 1'b1, '0, '0, '1);
    tag = "R3"; kc(1'b0, 6'd3, '0, '1, 1'b1, '0, '0, '1); idle(3);
    // R6: partial lanes in both beats
    tag = "R6"; kc(1'b1, '0, '0, '1, 1'b0, 6'd3, 18'h3FFFF, 2'b10);
    kc(1'b1, '0, 18'h00000, 2'b01, 1'b1, '0, '0, '1);
    kc(1'b0, 6'd3, '0, '1, 1'b1, '0, '0, '1); idle(3);
    // R7: read and write in one K cycle, same address -> old data
    tag = "R7"; kc(1'b0, 6'd3, '0, '1, 1'b0, 6'd3, 18'h12345, 2'b00);
    kc(1'b1, '0, 18'h0ABCD, 2'b00, 1'b1, '0, '0, '1); idle(3);
    kc(1'b0, 6'd3, '0, '1, 1'b1, '0, '0, '1); idle(3);
    // R8: read lands with the second beat -> forwarded masked word
    tag = "R8"; kc(1'b1, '0, '0, '1, 1'b0, 6'd3, 18'h3E1F0, 2'b01);
    kc(1'b0, 6'd3, 18'h21D2E, 2'b10, 1'b1, '0, '0, '1); idle(3);
    // R10: back-to-back reads
    tag = "R10";
    for (int a = 10; a < 13; a++) begin
      kc(1'b1, '0, '0, '1, 1'b0, AW'(a), DW'(a * 1111), 2'b00);
      kc(1'b1, '0, DW'(a * 2222), 2'b00, 1'b1, '0, '0, '1);
    end
    kc(1'b0, 6'd10, '0, '1, 1'b1, '0, '0, '1);
    kc(1'b0, 6'd11, '0, '1, 1'b1, '0, '0, '1);
    kc(1'b0, 6'd12, '0, '1, 1'b1, '0, '0, '1); idle(3);
    // R4: reads with a gap -> valid drops between bursts
    tag = "R4"; kc(1'b0, 6'd3, '0, '1, 1'b1, '0, '0, '1); idle(1);
    kc(1'b0, 6'd11, '0, '1, 1'b1, '0, '0, '1); idle(3);
    // R11: write command in a K-rising slot is ignored
    tag = "R11"; do_slot(1'b1, '0, 1'b0, 6'd9, 18'h155AA, 2'b00);
    do_slot(1'b1, '0, 1'b1, '0, 18'h2AA55, 2'b00);
    kc(1'b0, 6'd9, '0, '1, 1'b1, '0, '0, '1); idle(3);
    // R2: read command in a K-falling slot is ignored
    tag = "R2"; do_slot(1'b1, '0, 1'b1, '0, '0, '1);
    do_slot(1'b0, 6'd3, 1'b1, '0, '0, '1); idle(4);
    // R9: long idle, output must hold
    tag = "R9"; idle(4);
    // Random collisions over four addresses
    tag = "R3";
    for (int n = 0; n < 400; n++) begin
      logic [DW-1:0] dh, dl;
      dh = DW'($urandom()); dl = DW'($urandom());
      kc(1'($urandom_range(0, 1)), AW'($urandom_range(0, 3)), dh, LN'($urandom_range(0, 3)),
         1'($urandom_range(0, 1)), AW'($urandom_range(0, 3)), dl, LN'($urandom_range(0, 3)));
    end
    kc(1'b1, '0, DW'($urandom()), '0, 1'b1, '0, '0, '1);
    idle(4);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule